// File: doc/BRIEF.md
# Buffered Output-Compare PWM Timer

This block is a free-running 16-bit timer that drives two output-compare channels. The up-counter starts at zero, counts up to a programmable modulo limit and then wraps to zero. Each wrap is an overflow. Each channel compares the count against its own compare register. At overflow the channel's pin is driven to its active level, and on a compare match it is driven to the inactive level. The result is a PWM signal whose period is set by the modulo limit and whose pulse width is set by the compare value.

Setting the link bit in channel 0's control register joins the two compare registers into one buffered source that drives pin 0 only. Software writes the next duty value into the register that is not currently in use. At the following overflow that register takes over, so the duty cycle changes without a glitch. A write to the register that is in use takes effect at once.

All registers are loaded through a single-cycle write port (`wr_en`, `wr_addr`, `wr_data`). Register addresses: 0 is the modulo limit, 1 is control 0, 2 is compare 0, 3 is control 1 and 4 is compare 1.

Top module: `bufpwm_timer`

## Requirements
- R1: The counter runs 0,1,…,M, where M is the modulo limit at address 0. It returns to 0 on the clock after the count reaches M, or after it exceeds M. `ovf_o` is high for exactly the one clock after each wrap, so pulses are M+1 clocks apart.
- R2: After reset, `pin_o`, `ovf_o` and `match_o` are all 0.
- R3: Control bits are: bit0 enable, bit1 overflow-drive, bit2 polarity (1 = active high) and bit3 link (control 0 only). Control 0 is at address 1 and control 1 at address 3. With enable and overflow-drive set, each overflow drives the pin to its active level.
- R4: A compare match drives the pin to the inactive level. The compare values are at address 2 (set 0) and address 4 (set 1). For a compare value C < M, the pin is at its active level for C+1 clocks of each M+1-clock period. This holds for both polarities.
- R5: A compare value ≥ M keeps the pin active for the whole period (100% duty). A compare value > M never produces a match pulse.
- R6: `match_o[k]` pulses for one clock, in the clock after the count equals channel k's active compare value.
- R7: While linked, compare set 0 controls pin 0 at first. `pin_o[1]` and `match_o[1]` stay 0, and control 1 has no effect.
- R8: While linked, a write to compare set 1 hands control to set 1 only at the next overflow. The current period keeps the old width.
- R9: At each overflow while linked, the set written most recently becomes the controlling set. If neither set has been written since, the controlling set does not change.
- R10: While linked, a write to the controlling set takes effect within the current period.
- R11: A compare write on the same clock as an overflow counts as earlier than that overflow, so the written set controls the period that follows.
- R12: Clearing the link bit makes set 0 control pin 0 again and restores channel 1 as an independent channel.
- R13: While unlinked, the two channels run at the same time, each with its own control and compare registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pin_o | output | 2 | Channel output pins |
| ovf_o | output | 1 | One-clock overflow pulse |
| match_o | output | 2 | One-clock compare-match pulses |

## Verification
The assertions assume that at most one register is written per clock, which the single write port guarantees. They also assume that a modulo limit of 0 is never used together with match pulses. The hand-over properties assume that only the compare-register write strobes change the remembered set. The stimulus writes registers only on the falling edge and sets the modulo limit well above zero before any PWM measurement. It changes compare values only at known count positions: just after an overflow, or on the overflow clock itself.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MOD  = 3'd0,
    RA_CTL0 = 3'd1,
    RA_CMP0 = 3'd2,
    RA_CTL1 = 3'd3,
    RA_CMP1 = 3'd4
  } reg_addr_e;

  // control byte layout: bit0 enable, bit1 overflow-drive, bit2 polarity, bit3 link
  typedef struct packed {
    logic link;
    logic pol;
    logic tov;
    logic en;
  } chan_ctl_t;

  localparam int CTL_W = $bits(chan_ctl_t);
endpackage

// File: rtl/tim_counter.sv
module tim_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] count_q;
  logic             ovf_q;

  function automatic logic at_limit(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
    return c >= m;
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic w);
    return w ? '0 : c + 1'b1;
  endfunction

  assign wrap_o = at_limit(count_q, mod_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= step(count_q, wrap_o);
      ovf_q   <= wrap_o;
    end
  end

  assign count_o = count_q;
  assign ovf_o   = ovf_q;

  p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (count_q == '0));
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> (count_q == CNT_W'($past(count_q) + 1'b1)));
  p_ovf_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> ovf_q);
endmodule

// File: rtl/tim_link_sel.sv
module tim_link_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic link_i,
  input  logic wrap_i,
  input  logic wr_set0_i,
  input  logic wr_set1_i,
  output logic active_o
);
  logic active_q;
  logic last_q;

  // a write on the overflow clock wins over the remembered set
  function automatic logic pick_next(input logic last, input logic w0, input logic w1);
    if (w1) return 1'b1;
    if (w0) return 1'b0;
    return last;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      last_q   <= 1'b0;
    end else if (!link_i) begin
      active_q <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      last_q <= pick_next(last_q, wr_set0_i, wr_set1_i);
      if (wrap_i) active_q <= pick_next(last_q, wr_set0_i, wr_set1_i);
    end
  end

  assign active_o = active_q;

  p_hold_between_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && !wrap_i) |=> $stable(active_q));
  p_follow_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && wrap_i && !wr_set0_i && !wr_set1_i) |=> (active_q == $past(last_q)));
  p_same_clock_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && wrap_i && wr_set1_i) |=> active_q);
  p_unlink_ch0_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !link_i |=> !active_q);
endmodule

// File: rtl/tim_oc_chan.sv
module tim_oc_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tov_i,
  input  logic             pol_i,
  input  logic             idle_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wrap_i,
  output logic             pin_o,
  output logic             match_o
);
  logic pin_q;
  logic match_q;
  logic live;
  logic hit;

  function automatic logic is_hit(input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] cmp,
                                  input logic [CNT_W-1:0] m);
    return (cmp <= m) && (c == cmp);
  endfunction

  assign live = en_i && !idle_i;
  assign hit  = live && is_hit(count_i, cmp_i, mod_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit;
      if (!live)                pin_q <= 1'b0;
      else if (wrap_i && tov_i) pin_q <= pol_i;
      else if (hit)             pin_q <= ~pol_i;
    end
  end

  assign pin_o   = pin_q;
  assign match_o = match_q;

  p_ovf_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && tov_i && wrap_i) |=> (pin_q == $past(pol_i)));
  p_cmp_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(wrap_i && tov_i)) |=> (pin_q == !$past(pol_i)));
  p_no_match_beyond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_i > mod_i) |=> !match_q);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> (!pin_q && !match_q));
endmodule

// File: rtl/bufpwm_timer.sv
module bufpwm_timer
  import bufpwm_pkg::*;
#(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] MOD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [1:0]       pin_o,
  output logic             ovf_o,
  output logic [1:0]       match_o
);
  logic [CNT_W-1:0] mod_q;
  chan_ctl_t        ctl_q [NUM_CH];
  logic [CNT_W-1:0] cmp_q [NUM_CH];
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             active;
  logic             linked;
  logic             wr_set0;
  logic             wr_set1;
  reg_addr_e        addr;

  assign addr    = reg_addr_e'(wr_addr);
  assign wr_set0 = wr_en && (addr == RA_CMP0);
  assign wr_set1 = wr_en && (addr == RA_CMP1);
  assign linked  = ctl_q[0].link;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= MOD_RST;
      for (int k = 0; k < NUM_CH; k++) begin
        ctl_q[k] <= '0;
        cmp_q[k] <= '0;
      end
    end else if (wr_en) begin
      case (addr)
        RA_MOD:  mod_q    <= wr_data;
        RA_CTL0: ctl_q[0] <= chan_ctl_t'(wr_data[CTL_W-1:0]);
        RA_CMP0: cmp_q[0] <= wr_data;
        RA_CTL1: ctl_q[1] <= chan_ctl_t'({1'b0, wr_data[CTL_W-2:0]});
        RA_CMP1: cmp_q[1] <= wr_data;
        default: ;
      endcase
    end
  end

  tim_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_i   (mod_q),
    .count_o (count),
    .wrap_o  (wrap),
    .ovf_o   (ovf_o)
  );

  tim_link_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_i    (linked),
    .wrap_i    (wrap),
    .wr_set0_i (wr_set0),
    .wr_set1_i (wr_set1),
    .active_o  (active)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [CNT_W-1:0] eff_cmp;
    logic             idle;
    if (k == 0) begin : g_lead
      assign eff_cmp = (linked && active) ? cmp_q[1] : cmp_q[0];
      assign idle    = 1'b0;
    end else begin : g_follow
      assign eff_cmp = cmp_q[k];
      assign idle    = linked;
    end
    tim_oc_chan #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (ctl_q[k].en),
      .tov_i   (ctl_q[k].tov),
      .pol_i   (ctl_q[k].pol),
      .idle_i  (idle),
      .cmp_i   (eff_cmp),
      .mod_i   (mod_q),
      .count_i (count),
      .wrap_i  (wrap),
      .pin_o   (pin_o[k]),
      .match_o (match_o[k])
    );
  end

  p_pin1_linked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    linked |=> !pin_o[1]);
endmodule

// File: tb/bufpwm_timer_test.sv
module bufpwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  pin_o;
  logic        ovf_o;
  logic [1:0]  match_o;

  int checks = 0;
  int errors = 0;
  int cur_mod = 0;

  localparam logic [2:0] A_MOD = 3'd0, A_CTL0 = 3'd1, A_CMP0 = 3'd2, A_CTL1 = 3'd3, A_CMP1 = 3'd4;

  bufpwm_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_o(pin_o), .ovf_o(ovf_o), .match_o(match_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a == A_MOD) cur_mod = d;
  endtask

  // one full period from an overflow sample: active-level samples and match pulses
  task automatic measure(input int ch, input logic lvl, output int act, output int m);
    while (!ovf_o) @(negedge clk);
    act = 0; m = 0;
    for (int i = 0; i <= cur_mod; i++) begin
      if (pin_o[ch] == lvl) act++;
      if (match_o[ch]) m++;
      @(negedge clk);
    end
  endtask

  task automatic rest(input int ch, input logic lvl, output int act);
    act = 0;
    for (int i = 0; i < cur_mod; i++) begin
      if (pin_o[ch] == lvl) act++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 pins", int'(pin_o), 0);
    check("R2 ovf", int'(ovf_o), 0);
    check("R2 match", int'(match_o), 0);
  endtask

  task automatic t_period();
    int n;
    wr(A_MOD, 9);
    while (!ovf_o) @(negedge clk);
    @(negedge clk);
    check("R1 ovf one clock", int'(ovf_o), 0);
    n = 1;
    while (!ovf_o) begin n++; @(negedge clk); end
    check("R1 ovf spacing", n, 10);
  endtask

  task automatic t_unbuffered();
    int a, m;
    wr(A_CTL0, 7); wr(A_CMP0, 3);
    wr(A_CTL1, 3); wr(A_CMP1, 6);
    measure(0, 1'b1, a, m);
    measure(0, 1'b1, a, m);
    check("R3 R4 active-high width", a, 4);
    check("R6 match pulses per period", m, 1);
    measure(1, 1'b0, a, m);
    check("R4 R13 active-low width ch1", a, 7);
  endtask

  task automatic t_full();
    int a, m;
    wr(A_CMP0, 12);
    measure(0, 1'b1, a, m);
    measure(0, 1'b1, a, m);
    check("R5 compare above limit duty", a, 10);
    check("R5 no match above limit", m, 0);
    wr(A_CMP0, 9);
    measure(0, 1'b1, a, m);
    measure(0, 1'b1, a, m);
    check("R5 compare at limit duty", a, 10);
  endtask

  task automatic t_linked();
    int a, m;
    wr(A_CTL1, 7); wr(A_CMP1, 6);
    wr(A_CMP0, 2);
    wr(A_CTL0, 15);
    measure(0, 1'b1, a, m);
    measure(0, 1'b1, a, m);
    check("R7 set0 controls first", a, 3);
    measure(1, 1'b1, a, m);
    check("R7 pin1 held low", a, 0);
    check("R7 match1 quiet", m, 0);
    // R8: set 1 written early in a period, old width kept for this period
    wr(A_CMP1, 6);
    rest(0, 1'b1, a);
    check("R8 no early switch", a, 2);
    measure(0, 1'b1, a, m);
    check("R8 set1 after overflow", a, 7);
    measure(0, 1'b1, a, m);
    check("R9 set1 keeps control", a, 7);
    wr(A_CMP0, 4);
    rest(0, 1'b1, a);
    check("R9 set1 until overflow", a, 6);
    measure(0, 1'b1, a, m);
    check("R9 set0 last written", a, 5);
    // R10: write to the set in control, effect within this period
    wr(A_CMP0, 7);
    rest(0, 1'b1, a);
    check("R10 immediate write", a, 7);
    measure(0, 1'b1, a, m);
    check("R10 next period", a, 8);
    // R11: write on the overflow clock itself
    repeat (cur_mod) @(negedge clk);
    wr(A_CMP1, 1);
    measure(0, 1'b1, a, m);
    check("R11 same-clock write", a, 2);
  endtask

  task automatic t_unlink();
    int a, m;
    wr(A_CTL0, 7);
    measure(0, 1'b1, a, m);
    measure(0, 1'b1, a, m);
    check("R12 set0 back in control", a, 8);
    measure(1, 1'b1, a, m);
    check("R12 R13 ch1 independent again", a, 2);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_unbuffered();
    t_full();
    t_linked();
    t_unlink();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule